// File: doc/BRIEF.md
# Cascaded Two-Stage Noise-Shaping Digital Modulator

This block turns a wide signed sample stream into a four-level code whose quantization noise is pushed towards high frequencies with second-order shaping. It contains two first-order digital modulators in a chain. Each one is a wrapping accumulator. The carry out of the accumulator is that stage's one-bit decision, and the value left in the accumulator is the error that the next stage receives. A small cancellation network combines the two one-bit streams so that the noise of the first stage drops out. Only the noise of the second stage remains, and it is filtered by (1 - z^-1)^2.

A sample is taken on each clock for which the clock enable is high. The result is a registered two-bit code from 0 to 3, meant for a four-level converter placed after the block. First-order stages cannot go unstable, so any in-range input word is accepted without a limiter.

Top module: `mash2_mod`

## Requirements
- R1: A synchronous active-high reset clears both accumulators and both stored decision bits to zero. It also sets the output code to 1 (the zero level) and drops the valid flag.
- R2: The input word is two's complement with width DW. Stage one adds the offset value u = din + 2^(DW-1) to its accumulator modulo 2^DW. Its decision bit is 1 exactly when that sum reaches 2^DW.
- R3: On each enabled sample, stage two adds the residue that stage one held before that sample to its own accumulator, modulo 2^DW. Its decision bit is 1 when that sum reaches 2^DW. When both residues are zero, the stage-two residue stays zero.
- R4: On each enabled sample the output code becomes c1_prev + c2 - c2_prev + 1. Here c1_prev and c2_prev are the decisions of stage one and stage two from the previous enabled sample (0 after reset), and c2 is the new decision of stage two. The code appears on the clock edge that takes the sample.
- R5: Two valid codes in a row are never both 0 and never both 3.
- R6: While the clock enable is low, no state changes: the code holds its value whatever din is.
- R7: code_vld is high for exactly one cycle after each clock edge at which ce was high.
- R8: For a constant input held for N enabled samples after reset, the sum of the codes lies within 2 of N*(1 + u/2^DW).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Sample enable; one input word is taken per high cycle |
| din | input | DW | Signed input sample |
| code | output | 2 | Four-level output code, 0..3, registered |
| code_vld | output | 1 | High when code was updated by the last edge |

## Verification
A wrong accumulator residue or decision bit in either stage does not stay hidden. It changes the code within one or two enabled samples, because every decision enters the combined code directly and again through the difference term. A corrupted stage-one residue reaches the code one sample later through stage two. Over a long stretch at a constant input it also moves the average code away from the input level. The bench therefore compares every single code with a bit-true model. In addition it checks the long-run average, the adjacency rule and the behaviour while the enable is low.

// File: rtl/mash_pkg.sv
`timescale 1ns/1ps
package mash_pkg;
  localparam int CODE_W   = 2;
  localparam int N_STAGES = 2;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_MID = code_t'(1);
endpackage

// File: rtl/mash_acc_stage.sv
`timescale 1ns/1ps
// One first-order stage: a wrapping accumulator whose carry is the decision.
module mash_acc_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] add_i,
  output logic         carry_o,
  output logic [W-1:0] res_o
);
  logic [W:0] sum;

  always_comb begin
    sum     = {1'b0, res_o} + {1'b0, add_i};
    carry_o = sum[W];
  end

  always_ff @(posedge clk) begin
    if (rst)     res_o <= '0;
    else if (ce) res_o <= sum[W-1:0];
  end
endmodule

// File: rtl/mash_recombine.sv
`timescale 1ns/1ps
// Noise cancellation: delayed first-stage bit plus differenced second-stage bit.
module mash_recombine
  import mash_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ce,
  input  logic  c1_i,
  input  logic  c2_i,
  output code_t code_o,
  output logic  vld_o
);
  logic  c1_q, c2_q;
  code_t nxt;

  always_comb begin
    nxt = code_t'(c1_q) + code_t'(c2_i) + CODE_MID - code_t'(c2_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c1_q   <= 1'b0;
      c2_q   <= 1'b0;
      code_o <= CODE_MID;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= ce;
      if (ce) begin
        c1_q   <= c1_i;
        c2_q   <= c2_i;
        code_o <= nxt;
      end
    end
  end
endmodule

// File: rtl/mash2_mod.sv
`timescale 1ns/1ps
module mash2_mod
  import mash_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [DW-1:0] din,
  output logic [1:0]    code,
  output logic          code_vld
);
  localparam int NS = N_STAGES;

  logic [DW-1:0] link  [NS+1];
  logic [NS-1:0] carry;
  code_t         code_w;

  // Signed to offset binary: invert the sign bit.
  assign link[0] = {~din[DW-1], din[DW-2:0]};

  for (genvar i = 0; i < NS; i++) begin : g_stage
    mash_acc_stage #(.W(DW)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .ce     (ce),
      .add_i  (link[i]),
      .carry_o(carry[i]),
      .res_o  (link[i+1])
    );
  end

  mash_recombine u_comb (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce),
    .c1_i  (carry[0]),
    .c2_i  (carry[NS-1]),
    .code_o(code_w),
    .vld_o (code_vld)
  );

  assign code = code_w;
endmodule

// File: rtl/mash2_chk.sv
`timescale 1ns/1ps
module mash2_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ce,
  input logic [1:0]   code,
  input logic         code_vld,
  input logic [W-1:0] res1,
  input logic [W-1:0] res2
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code == 2'd1 && !code_vld)); // R1

  AST_ZERO_RESIDUE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (ce && res1 == '0 && res2 == '0) |=> (res2 == '0)); // R3

  AST_NO_REPEAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (code_vld && code == 2'd0) |=> !(code_vld && code == 2'd0)); // R5

  AST_NO_REPEAT_CEIL: assert property (@(posedge clk) disable iff (rst)
    (code_vld && code == 2'd3) |=> !(code_vld && code == 2'd3)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ce && !$past(rst)) |=> $stable(code)); // R6

  AST_VALID_FOLLOWS_CE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (code_vld == $past(ce))); // R7
endmodule

bind mash2_mod mash2_chk #(.W(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .code    (code),
  .code_vld(code_vld),
  .res1    (link[1]),
  .res2    (link[2])
);

// File: tb/sim_mash2_mod.sv
`timescale 1ns/1ps
module sim_mash2_mod;
  localparam int DW = 16;
  localparam longint M = 64'd1 << DW;
  localparam longint H = M / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce  = 1'b0;
  logic [DW-1:0] din = '0;
  logic [1:0]    code;
  logic          code_vld;

  int checks = 0;
  int errors = 0;

  // reference state
  longint e1, e2;
  int c1p, c2p, exp_code;
  longint code_sum;

  always #5 clk = ~clk;

  mash2_mod #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .code(code), .code_vld(code_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    e1 = 0; e2 = 0; c1p = 0; c2p = 0; exp_code = 1;
  endfunction

  // Bit-true reference from the requirements (R2, R3, R4)
  function automatic void model_step(input longint x);
    longint u, s1, s2;
    int c1, c2;
    u  = x + H;
    s1 = e1 + u;
    s2 = e2 + e1;
    c1 = (s1 >= M) ? 1 : 0;
    c2 = (s2 >= M) ? 1 : 0;
    exp_code = c1p + c2 - c2p + 1;
    e1 = s1 % M;
    e2 = s2 % M;
    c1p = c1;
    c2p = c2;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ce = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one enabled sample, checked away from the edge
  task automatic sample(input longint x, input string req);
    int prev;
    prev = code;
    din = DW'(x);
    ce = 1'b1;
    model_step(x);
    @(negedge clk);
    ce = 1'b0;
    check(req, code, exp_code);
    check("R7", code_vld, 1);
    if (prev == 0 && code == 0) check("R5", 1, 0);
    if (prev == 3 && code == 3) check("R5", 1, 0);
  endtask

  task automatic idle(input longint x);
    int held;
    held = code;
    din = DW'(x);
    ce = 1'b0;
    @(negedge clk);
    check("R6", code, held);
    check("R7", code_vld, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();
    check("R1", code, 1);
    check("R1", code_vld, 0);

    // zero input: mid-scale offset
    for (int i = 0; i < 20; i++) sample(0, "R4");
    // most negative: stage one never carries
    for (int i = 0; i < 12; i++) sample(-H, "R2");
    // most positive
    for (int i = 0; i < 12; i++) sample(H - 1, "R2");
    // small steps around zero exercise stage-two residues
    for (int i = 0; i < 16; i++) sample((i % 2) ? 1 : -1, "R3");

    // enable low: state untouched while din changes
    for (int i = 0; i < 6; i++) idle(longint'($urandom % 65536) - H);
    sample(1234, "R6");

    // reset in mid-stream
    do_reset();
    check("R1", code, 1);
    check("R1", code_vld, 0);
    sample(H - 1, "R1");

    // constrained random with random gaps
    for (int i = 0; i < 1500; i++) begin
      longint x;
      x = longint'($urandom % 65536) - H;
      if (($urandom % 4) == 0) idle(x);
      else sample(x, "R4");
    end

    // long-run average at constant input (R8)
    do_reset();
    code_sum = 0;
    for (int i = 0; i < 256; i++) begin
      sample(12345, "R4");
      code_sum += code;
    end
    begin
      longint dev;
      dev = code_sum * M - 256 * (M + 12345 + H);
      if (dev < 0) dev = -dev;
      check("R8", (dev <= 2 * M) ? 1 : 0, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule